// File: doc/BRIEF.md
# Auto power-down sequencing serial master for a SAR converter

This block drives the serial port of a successive-approximation converter that can power itself down after each conversion. Every frame it sends a 16-bit control word carrying the power-mode pair, reads back a 16-bit sample, and tracks the point inside the frame where the converter drops into its low-power state. Once chip-select has risen, it starts a timer whose length depends on the mode. The next valid conversion frame is held off until that timer has expired.

User logic raises a one-cycle request and presents a mode on `mode_sel`. The first request after reset is served by a frame that only programs the converter, followed by the real conversion. Each conversion frame returns its word with a one-cycle strobe. The converter keeps its register contents through both low-power states, so the controller does not reprogram after a wake-up. A new mode takes effect in the control word of the next frame. The wait after a frame is set by the mode that frame wrote.

Top module: `adc_autopd_ctrl`

## Requirements
- R1: A frame holds `cs_n` low for exactly 16 serial clock periods. `sclk` is high whenever `cs_n` is high. There are 16 rising `sclk` edges per frame, and `sdi` and `sdo` are both shifted MSB first. Each `sclk` level lasts `HALF_DIV` system clocks.
- R2: The control word has bit 15 = 1 (write), the mode pair at bits [5:4] and the reference-enable bit 2 = 1, with all other bits 0. This gives 16'h8004 for normal mode, 16'h8014 for auto-standby and 16'h8024 for auto-shutdown.
- R3: `mode_sel` = 2'b00 selects normal, 2'b01 auto-standby and 2'b10 auto-shutdown. The value 2'b11 is sent as normal (pair 00).
- R4: The first request after reset produces a programming frame without `res_valid`, followed by a conversion frame that does assert it.
- R5: In a frame whose word selects an auto mode, `lowpwr` is 0 at the 14th rising `sclk` edge. It is 1 from the 15th rising edge until `cs_n` rises, when it returns to 0. In a frame whose word selects normal mode it stays 0.
- R6: After a frame that wrote auto-shutdown, `cs_n` stays high for at least ceil(CLK_HZ*SHUT_NS/1e9) cycles before the next frame.
- R7: After an auto-standby frame, `cs_n` stays high for at least ceil(CLK_HZ*STBY_NS/1e9) cycles. After a normal-mode frame, a pending request starts the next frame one cycle after `cs_n` rises.
- R8: A request made during a wait is held, not dropped. `busy` is 1 in the cycle after a request. Several requests made during one wait produce a single frame.
- R9: Each conversion frame gives exactly one one-cycle `res_valid` pulse, just after `cs_n` rises, with `res_data` equal to the 16 bits sampled from `sdo`.
- R10: A mode change appears in the next frame's control word. The wait before that frame is the one set by the mode of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | input | 1 | One-cycle conversion request |
| mode_sel | input | 2 | Requested power mode |
| sdo | input | 1 | Serial data returned by the converter |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock, idles high |
| sdi | output | 1 | Serial data to the converter's control register |
| busy | output | 1 | Frame running, wake timer running, or request pending |
| lowpwr | output | 1 | Converter is in its low-power state inside the current frame |
| res_valid | output | 1 | One-cycle strobe for a captured sample |
| res_data | output | 16 | Captured sample word |

## Verification
The bench steps through the modes: normal, auto-standby, auto-shutdown, a change from shutdown back to normal, and the reserved code 11. For each, it compares the captured control word, the `lowpwr` profile across the 14th, 16th and post-frame points, and the chip-select high gap before the next frame. The mode-change case shows whether the wait follows the previous frame's mode or the newly requested one. Back-to-back requests issued during a wait show whether requests are held and merged into one frame. Differing sample words per scenario expose bit-order or capture-window faults in the returned data.

// File: rtl/adcpd_pkg.sv
package adcpd_pkg;

   typedef enum logic [1:0] {
      PM_NORMAL = 2'b00,
      PM_STBY   = 2'b01,
      PM_SHDN   = 2'b10,
      PM_FULL   = 2'b11
   } pm_mode_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'b00,
      SQ_CFG  = 2'b01,
      SQ_CONV = 2'b10
   } seq_st_t;

   function automatic pm_mode_t pm_sanitize(input logic [1:0] m);
      pm_mode_t r;
      r = pm_mode_t'(m);
      if (r == PM_FULL) r = PM_NORMAL;
      return r;
   endfunction

   function automatic logic pm_is_auto(input pm_mode_t m);
      return (m == PM_STBY) || (m == PM_SHDN);
   endfunction

endpackage

// File: rtl/adcpd_ctrl_word.sv
module adcpd_ctrl_word
   import adcpd_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int WR_BIT  = 15,
   parameter int PM_LSB  = 4,
   parameter int REF_BIT = 2
) (
   input  pm_mode_t          mode,
   output logic [WORD_W-1:0] word
);

   if (WR_BIT >= WORD_W || PM_LSB + 1 >= WORD_W || REF_BIT >= WORD_W) begin : g_bad_pos
      $error("adcpd_ctrl_word: field position outside word");
   end
   if (WR_BIT == REF_BIT || WR_BIT == PM_LSB || WR_BIT == PM_LSB + 1 ||
       REF_BIT == PM_LSB || REF_BIT == PM_LSB + 1) begin : g_overlap
      $error("adcpd_ctrl_word: overlapping fields");
   end

   always_comb begin
      word               = '0;
      word[WR_BIT]       = 1'b1;
      word[PM_LSB+1 -: 2] = mode;
      word[REF_BIT]      = 1'b1;
   end

endmodule

// File: rtl/adcpd_wake_timer.sv
module adcpd_wake_timer
   import adcpd_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 100_000_000,
   parameter int unsigned SHUT_NS = 500_000,
   parameter int unsigned STBY_NS = 750
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load,
   input  pm_mode_t mode,
   output logic     busy
);

   localparam longint unsigned NS_PER_S = 64'd1_000_000_000;
   localparam longint unsigned SHUT_CYC =
      (64'(CLK_HZ) * 64'(SHUT_NS) + NS_PER_S - 64'd1) / NS_PER_S;
   localparam longint unsigned STBY_CYC =
      (64'(CLK_HZ) * 64'(STBY_NS) + NS_PER_S - 64'd1) / NS_PER_S;
   localparam longint unsigned MAX_CYC = (SHUT_CYC > STBY_CYC) ? SHUT_CYC : STBY_CYC;
   localparam int CNT_W = (MAX_CYC < 64'd2) ? 1 : $clog2(MAX_CYC + 64'd1);

   if (CLK_HZ == 0) begin : g_bad_clk
      $error("adcpd_wake_timer: CLK_HZ must be non-zero");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      case (mode)
         PM_SHDN: load_val = CNT_W'(SHUT_CYC);
         PM_STBY: load_val = CNT_W'(STBY_CYC);
         default: load_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
   end

   assign busy = (cnt != '0);

   assert_count_down_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !load) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/adcpd_shifter.sv
module adcpd_shifter #(
   parameter int WORD_W   = 16,
   parameter int HALF_DIV = 2,
   parameter int PD_EDGE  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              sdo,
   output logic              cs_n,
   output logic              sclk,
   output logic              sdi,
   output logic [WORD_W-1:0] rx_word,
   output logic              pd_edge,
   output logic              last
);

   localparam int HALVES = 2 * WORD_W;
   localparam int HC_W   = $clog2(HALVES);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("adcpd_shifter: HALF_DIV must be at least 1");
   end
   if (PD_EDGE < 1 || PD_EDGE > WORD_W) begin : g_bad_edge
      $error("adcpd_shifter: PD_EDGE outside frame");
   end

   logic              tick;
   logic [HC_W-1:0]   hcnt;
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;

   if (HALF_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      localparam int DC_W = $clog2(HALF_DIV);
      logic [DC_W-1:0] dcnt;
      always_ff @(posedge clk) begin
         if (!rst_n)     dcnt <= '0;
         else if (cs_n)  dcnt <= '0;
         else if (tick)  dcnt <= '0;
         else            dcnt <= dcnt + DC_W'(1);
      end
      assign tick = (dcnt == DC_W'(HALF_DIV - 1));
   end

   assign pd_edge = !cs_n && tick && (hcnt == HC_W'(2 * PD_EDGE - 2));
   assign last    = !cs_n && tick && (hcnt == HC_W'(HALVES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_n  <= 1'b1;
         sclk  <= 1'b1;
         hcnt  <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (cs_n) begin
         if (start) begin
            cs_n  <= 1'b0;
            sclk  <= 1'b0;
            hcnt  <= '0;
            tx_sh <= tx_word;
         end
      end else if (tick) begin
         if (last) begin
            cs_n <= 1'b1;
            sclk <= 1'b1;
         end else begin
            hcnt <= hcnt + HC_W'(1);
            sclk <= ~sclk;
            if (!sclk) rx_sh <= {rx_sh[WORD_W-2:0], sdo};
            else       tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
         end
      end
   end

   assign sdi     = tx_sh[WORD_W-1];
   assign rx_word = rx_sh;

   assert_sclk_idle_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);
   assert_sclk_fall_in_frame_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> !cs_n);

endmodule

// File: rtl/adc_autopd_ctrl.sv
module adc_autopd_ctrl
   import adcpd_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 100_000_000,
   parameter int          HALF_DIV = 2,
   parameter int          WORD_W   = 16,
   parameter int          PD_EDGE  = 15,
   parameter int          WR_BIT   = 15,
   parameter int          PM_LSB   = 4,
   parameter int          REF_BIT  = 2,
   parameter int unsigned SHUT_NS  = 500_000,
   parameter int unsigned STBY_NS  = 750
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_req,
   input  logic [1:0]        mode_sel,
   input  logic              sdo,
   output logic              cs_n,
   output logic              sclk,
   output logic              sdi,
   output logic              busy,
   output logic              lowpwr,
   output logic              res_valid,
   output logic [WORD_W-1:0] res_data
);

   seq_st_t           st;
   pm_mode_t          req_mode;
   pm_mode_t          frm_mode;
   logic              programmed;
   logic              req_pend;
   logic              start;
   logic              wake_busy;
   logic              pd_edge;
   logic              last;
   logic [WORD_W-1:0] tx_word;
   logic [WORD_W-1:0] rx_word;

   assign req_mode = pm_sanitize(mode_sel);
   assign start    = (st == SQ_IDLE) && (req_pend || conv_req) &&
                     (!programmed || !wake_busy);

   adcpd_ctrl_word #(
      .WORD_W (WORD_W),
      .WR_BIT (WR_BIT),
      .PM_LSB (PM_LSB),
      .REF_BIT(REF_BIT)
   ) u_word (
      .mode(req_mode),
      .word(tx_word)
   );

   adcpd_shifter #(
      .WORD_W  (WORD_W),
      .HALF_DIV(HALF_DIV),
      .PD_EDGE (PD_EDGE)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .tx_word(tx_word),
      .sdo    (sdo),
      .cs_n   (cs_n),
      .sclk   (sclk),
      .sdi    (sdi),
      .rx_word(rx_word),
      .pd_edge(pd_edge),
      .last   (last)
   );

   adcpd_wake_timer #(
      .CLK_HZ (CLK_HZ),
      .SHUT_NS(SHUT_NS),
      .STBY_NS(STBY_NS)
   ) u_wake (
      .clk  (clk),
      .rst_n(rst_n),
      .load (last),
      .mode (frm_mode),
      .busy (wake_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         frm_mode   <= PM_NORMAL;
         programmed <= 1'b0;
         req_pend   <= 1'b0;
         res_valid  <= 1'b0;
         res_data   <= '0;
         lowpwr     <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         req_pend  <= req_pend | conv_req;
         if (start) begin
            frm_mode <= req_mode;
            if (programmed) begin
               st       <= SQ_CONV;
               req_pend <= 1'b0;
            end else begin
               st       <= SQ_CFG;
               req_pend <= 1'b1;
            end
         end
         if (last) begin
            st         <= SQ_IDLE;
            programmed <= 1'b1;
            lowpwr     <= 1'b0;
            if (st == SQ_CONV) begin
               res_valid <= 1'b1;
               res_data  <= rx_word;
            end
         end else if (pd_edge && pm_is_auto(frm_mode)) begin
            lowpwr <= 1'b1;
         end
      end
   end

   assign busy = (st != SQ_IDLE) || wake_busy || req_pend;

   assert_valid_one_cycle_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   assert_lowpwr_in_frame_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      lowpwr |-> !cs_n);
   assert_normal_no_lowpwr_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (frm_mode == PM_NORMAL) |-> !lowpwr);
   assert_wake_holdoff_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wake_busy && cs_n && programmed) |=> cs_n);
   assert_req_held_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> busy);

endmodule

// File: tb/adc_autopd_ctrl_tb.sv
module adc_autopd_ctrl_tb_top;

   localparam int SHUT_C = 400;
   localparam int STBY_C = 75;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_req = 1'b0;
   logic [1:0]  mode_sel = 2'b00;
   logic        sdo = 1'b0;
   logic        cs_n, sclk, sdi, busy, lowpwr, res_valid;
   logic [15:0] res_data;

   adc_autopd_ctrl #(
      .CLK_HZ  (100_000_000),
      .HALF_DIV(2),
      .SHUT_NS (4_000),
      .STBY_NS (750)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .conv_req (conv_req),
      .mode_sel (mode_sel),
      .sdo      (sdo),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .busy     (busy),
      .lowpwr   (lowpwr),
      .res_valid(res_valid),
      .res_data (res_data)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [15:0] adc_word = 16'h0000;
   logic [15:0] din_acc, last_din, last_data;
   int          sidx = 15;
   int          edge_cnt, last_edges, gap_cnt = 0, gap_last = 0;
   int          frames = 0, nvalid = 0;
   logic        cs_q = 1'b1, sclk_q = 1'b1;
   logic        lp_early, lp_at16, lp_after;

   always @(negedge clk) begin
      if (cs_q && !cs_n) begin
         frames++;
         gap_last = gap_cnt;
         gap_cnt  = 0;
         edge_cnt = 0;
         sidx     = 15;
         din_acc  = '0;
         lp_early = 1'b0;
         lp_at16  = 1'b0;
      end
      if (cs_n) gap_cnt++;
      if (!cs_n && !sclk_q && sclk) begin
         edge_cnt++;
         din_acc = {din_acc[14:0], sdi};
         if (sidx > 0) sidx--;
         if (edge_cnt == 14 && lowpwr) lp_early = 1'b1;
         if (edge_cnt == 16) lp_at16 = lowpwr;
      end
      if (!cs_q && cs_n) begin
         last_din   = din_acc;
         last_edges = edge_cnt;
         lp_after   = lowpwr;
      end
      if (res_valid) begin
         nvalid++;
         last_data = res_data;
      end
      sdo    = adc_word[sidx];
      cs_q   = cs_n;
      sclk_q = sclk;
   end

   task automatic chk_eq(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic chk_ge(input string rq, input string what, input int act, input int lim);
      n_chk++;
      if (act < lim) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected>=%0d", rq, what, act, lim);
      end
   endtask

   task automatic chk_le(input string rq, input string what, input int act, input int lim);
      n_chk++;
      if (act > lim) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected<=%0d", rq, what, act, lim);
      end
   endtask

   task automatic pulse_req();
      @(negedge clk);
      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
   endtask

   task automatic wait_valid(input int v0);
      int lim = 0;
      while (nvalid == v0 && lim < 5000) begin
         @(negedge clk);
         lim++;
      end
      chk_ge("R9", "result strobe seen", nvalid - v0, 1);
   endtask

   task automatic t_reset();
      chk_eq("R1", "cs_n after reset", cs_n, 1);
      chk_eq("R1", "sclk after reset", sclk, 1);
      chk_eq("R8", "busy after reset", busy, 0);
      chk_eq("R9", "res_valid after reset", res_valid, 0);
      chk_eq("R5", "lowpwr after reset", lowpwr, 0);
   endtask

   task automatic t_first_normal();
      int v0 = nvalid, f0 = frames;
      mode_sel = 2'b00;
      adc_word = 16'hA5C3;
      pulse_req();
      wait_valid(v0);
      chk_eq("R4", "frames for first request", frames - f0, 2);
      chk_eq("R4", "strobes for first request", nvalid - v0, 1);
      chk_eq("R2", "normal control word", last_din, 16'h8004);
      chk_eq("R9", "normal sample", last_data, 16'hA5C3);
      chk_eq("R1", "rising edges per frame", last_edges, 16);
      chk_le("R7", "gap after normal frame", gap_last, 1);
      chk_eq("R5", "normal lowpwr at 16th", lp_at16, 0);
   endtask

   task automatic t_standby();
      int v0 = nvalid, f0;
      mode_sel = 2'b01;
      adc_word = 16'h3C96;
      pulse_req();
      wait_valid(v0);
      chk_eq("R2", "standby control word", last_din, 16'h8014);
      chk_eq("R9", "standby sample", last_data, 16'h3C96);
      chk_eq("R5", "lowpwr before 15th", lp_early, 0);
      chk_eq("R5", "lowpwr at 16th", lp_at16, 1);
      chk_eq("R5", "lowpwr after cs rise", lp_after, 0);
      v0 = nvalid;
      f0 = frames;
      adc_word = 16'h0F01;
      pulse_req();
      chk_eq("R8", "busy while waiting", busy, 1);
      pulse_req();
      wait_valid(v0);
      chk_ge("R7", "standby wake gap", gap_last, STBY_C);
      chk_eq("R9", "held request sample", last_data, 16'h0F01);
      repeat (200) @(negedge clk);
      chk_eq("R8", "merged requests frame count", frames - f0, 1);
   endtask

   task automatic t_shutdown();
      int v0 = nvalid;
      mode_sel = 2'b10;
      adc_word = 16'h8001;
      pulse_req();
      wait_valid(v0);
      chk_eq("R2", "shutdown control word", last_din, 16'h8024);
      chk_eq("R5", "shutdown lowpwr at 16th", lp_at16, 1);
      v0 = nvalid;
      adc_word = 16'h7FFE;
      pulse_req();
      wait_valid(v0);
      chk_ge("R6", "shutdown wake gap", gap_last, SHUT_C);
      chk_eq("R9", "sample after shutdown", last_data, 16'h7FFE);
   endtask

   task automatic t_mode_change();
      int v0 = nvalid;
      mode_sel = 2'b00;
      adc_word = 16'h1234;
      pulse_req();
      wait_valid(v0);
      chk_ge("R10", "old mode wait kept", gap_last, SHUT_C);
      chk_eq("R10", "new mode in next word", last_din, 16'h8004);
      chk_eq("R5", "no lowpwr after switch to normal", lp_at16, 0);
      v0 = nvalid;
      pulse_req();
      wait_valid(v0);
      chk_le("R7", "no wait in normal", gap_last, 3);
   endtask

   task automatic t_mode11();
      int v0 = nvalid;
      mode_sel = 2'b11;
      adc_word = 16'hFEED;
      pulse_req();
      wait_valid(v0);
      chk_eq("R3", "mode 11 word", last_din, 16'h8004);
      chk_eq("R3", "mode 11 lowpwr", lp_at16, 0);
      chk_eq("R9", "mode 11 sample", last_data, 16'hFEED);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_normal();
      t_standby();
      t_shutdown();
      t_mode_change();
      t_mode11();
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R8 watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule